// File: doc/BRIEF.md
# Power-Management Event Enable and Routing

This block holds a 16-bit enable register for power-management events. It combines each enable with the matching event status input and turns the result into three requests: a system control interrupt (SCI), a system management interrupt (SMI, driven active-high here and inverted at the pad), and a wake request. Software reaches the register through a simple I/O port at byte offset 02h of a power-management window. Each write carries per-byte lane enables.

The enable bits live in three reset domains. The timer, global and power-button enables are cleared by the core reset. The PCIe wake-disable bit is cleared only by the resume-domain reset. The RTC enable is cleared only by the RTC-domain reset or by a power-button-override event. A separate control input chooses whether timer-overflow, power-button and RTC events go to SCI or to SMI. A power-button press always asks for wake, whatever its enable says.

Top module: `pm_evt_top`

## Requirements
- R1: When all three resets are asserted together, the register reads 0000h afterwards and all three request outputs are 0.
- R2: The register answers only at byte address 02h. Reads at any other address return 0, and writes at any other address leave the register unchanged.
- R3: On a write, `io_be[0]` gates bits 7:0 and `io_be[1]` gates bits 15:8. A lane whose enable is 0 keeps its old contents.
- R4: Only these bits are implemented: bit 0 (timer-overflow enable), bit 5 (global enable), bit 8 (power-button enable), bit 10 (RTC enable) and bit 14 (PCIe wake disable). Every other bit reads 0 even after it is written with 1.
- R5: Request outputs are registered and reflect the inputs of the previous clock. A timer overflow with its enable at 1 gives SCI when `sci_en` is 1 and SMI when `sci_en` is 0. With its enable at 0 it gives neither.
- R6: When the global enable and `gbl_sts` are both 1, SCI is asserted, whatever the value of `sci_en`.
- R7: When the power-button enable and `pbtn_sts` are both 1, SCI is asserted if `sci_en` is 1 and SMI is asserted if it is 0. `pbtn_sts` asserts wake regardless of the enable.
- R8: When the RTC enable and `rtc_sts` are both 1, wake is asserted, together with SCI if `sci_en` is 1 or SMI if it is 0.
- R9: `pcie_wake_sts` asserts wake only while bit 14 is 0. While bit 14 is 1, that input has no effect on any output.
- R10: Core reset clears bits 0, 5 and 8 and the request outputs. It leaves bits 10 and 14 unchanged, including when a write arrives in the same cycle.
- R11: Resume reset clears bit 14 only.
- R12: RTC reset or the power-button-override event clears bit 10 only, and wins over a write to bit 10 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| core_rst | input | 1 | Core-domain synchronous reset, active high |
| resume_rst | input | 1 | Resume-domain synchronous reset, active high |
| rtc_rst | input | 1 | RTC-domain synchronous reset, active high |
| pbo_evt | input | 1 | Power-button-override event; clears the RTC enable |
| io_addr | input | 8 | Byte address within the power-management I/O window |
| io_wr | input | 1 | Write strobe |
| io_be | input | 2 | Byte-lane enables for writes |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, combinational on the address |
| tmr_ovf_sts | input | 1 | Timer-overflow status |
| gbl_sts | input | 1 | Global status |
| pbtn_sts | input | 1 | Power-button status |
| rtc_sts | input | 1 | RTC event status |
| pcie_wake_sts | input | 1 | PCIe wake status |
| sci_en | input | 1 | Routes timer, button and RTC events to SCI (1) or SMI (0) |
| sci_out | output | 1 | SCI request, registered |
| smi_out | output | 1 | SMI request, active high, registered |
| wake_out | output | 1 | Wake request, registered |

## Verification
The hardest situations to reach from the ports involve reset-domain separation. One reset must arrive in the same cycle as a write to bits in another domain, and the bench must show that only the bits of the resetting domain clear. Directed steps combine each reset with an all-ones write. Random stimulus then mixes rare, independent resets with writes, partial byte enables and status patterns, and a bench-side model of the register predicts every read and every request.

// File: rtl/pm_evt_pkg.sv
`timescale 1ns/1ps
package pm_evt_pkg;
    localparam int REG_W  = 16;
    localparam int LANE_W = 8;
    localparam int NLANES = REG_W / LANE_W;

    localparam int B_TMR  = 0;
    localparam int B_GBL  = 5;
    localparam int B_PBTN = 8;
    localparam int B_RTC  = 10;
    localparam int B_PCIE = 14;

    typedef enum logic [1:0] {
        DOM_NONE,
        DOM_CORE,
        DOM_RESUME,
        DOM_RTC
    } rst_dom_e;

    typedef struct packed {
        logic tmr;
        logic gbl;
        logic pbtn;
        logic rtc;
        logic pcie;
    } evt_sts_t;

    typedef struct packed {
        logic sci;
        logic smi;
        logic wake;
    } pm_req_t;

    function automatic rst_dom_e dom_of(int b);
        case (b)
            B_TMR, B_GBL, B_PBTN: return DOM_CORE;
            B_PCIE:               return DOM_RESUME;
            B_RTC:                return DOM_RTC;
            default:              return DOM_NONE;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] impl_mask();
        logic [REG_W-1:0] m;
        for (int b = 0; b < REG_W; b++) m[b] = (dom_of(b) != DOM_NONE);
        return m;
    endfunction
endpackage

// File: rtl/pm_en_regs.sv
`timescale 1ns/1ps
module pm_en_regs
    import pm_evt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int REG_OFS = 2
) (
    input  logic              clk,
    input  logic              core_rst,
    input  logic              resume_rst,
    input  logic              rtc_rst,
    input  logic              pbo_evt,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [NLANES-1:0] io_be,
    input  logic [REG_W-1:0]  io_wdata,
    output logic [REG_W-1:0]  en_q,
    output logic [REG_W-1:0]  io_rdata
);
    logic hit;
    assign hit = (io_addr == ADDR_W'(REG_OFS));

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        localparam rst_dom_e DOM  = dom_of(b);
        localparam int       LANE = b / LANE_W;
        if (DOM == DOM_NONE) begin : g_rsvd
            assign en_q[b] = 1'b0;
        end else begin : g_impl
            logic clr;
            logic bit_q;
            if (DOM == DOM_CORE) begin : g_core
                assign clr = core_rst;
            end else if (DOM == DOM_RESUME) begin : g_res
                assign clr = resume_rst;
            end else begin : g_rtc
                assign clr = rtc_rst | pbo_evt;
            end
            always_ff @(posedge clk) begin
                if (clr)
                    bit_q <= 1'b0;
                else if (io_wr && hit && io_be[LANE])
                    bit_q <= io_wdata[b];
            end
            assign en_q[b] = bit_q;
        end
    end

    assign io_rdata = hit ? en_q : '0;
endmodule

// File: rtl/pm_evt_route.sv
`timescale 1ns/1ps
module pm_evt_route
    import pm_evt_pkg::*;
(
    input  logic [REG_W-1:0] en_q,
    input  evt_sts_t         sts,
    input  logic             sci_en,
    output pm_req_t          req
);
    logic tmr_hit, gbl_hit, pbtn_hit, rtc_hit;
    logic steer_any;

    assign tmr_hit   = en_q[B_TMR]  & sts.tmr;
    assign gbl_hit   = en_q[B_GBL]  & sts.gbl;
    assign pbtn_hit  = en_q[B_PBTN] & sts.pbtn;
    assign rtc_hit   = en_q[B_RTC]  & sts.rtc;
    assign steer_any = tmr_hit | pbtn_hit | rtc_hit;

    always_comb begin
        req.sci  = gbl_hit | (steer_any & sci_en);
        req.smi  = steer_any & ~sci_en;
        req.wake = sts.pbtn | rtc_hit | (sts.pcie & ~en_q[B_PCIE]);
    end
endmodule

// File: rtl/pm_req_reg.sv
`timescale 1ns/1ps
module pm_req_reg
    import pm_evt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pm_req_t d,
    output pm_req_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/pm_evt_top.sv
`timescale 1ns/1ps
module pm_evt_top
    import pm_evt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int REG_OFS = 2
) (
    input  logic              clk,
    input  logic              core_rst,
    input  logic              resume_rst,
    input  logic              rtc_rst,
    input  logic              pbo_evt,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [1:0]        io_be,
    input  logic [15:0]       io_wdata,
    output logic [15:0]       io_rdata,
    input  logic              tmr_ovf_sts,
    input  logic              gbl_sts,
    input  logic              pbtn_sts,
    input  logic              rtc_sts,
    input  logic              pcie_wake_sts,
    input  logic              sci_en,
    output logic              sci_out,
    output logic              smi_out,
    output logic              wake_out
);
    logic [REG_W-1:0] en_q;
    evt_sts_t         sts;
    pm_req_t          req_d, req_q;

    assign sts = '{tmr: tmr_ovf_sts, gbl: gbl_sts, pbtn: pbtn_sts,
                   rtc: rtc_sts, pcie: pcie_wake_sts};

    pm_en_regs #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_regs (
        .clk        (clk),
        .core_rst   (core_rst),
        .resume_rst (resume_rst),
        .rtc_rst    (rtc_rst),
        .pbo_evt    (pbo_evt),
        .io_addr    (io_addr),
        .io_wr      (io_wr),
        .io_be      (io_be),
        .io_wdata   (io_wdata),
        .en_q       (en_q),
        .io_rdata   (io_rdata)
    );

    pm_evt_route u_route (
        .en_q   (en_q),
        .sts    (sts),
        .sci_en (sci_en),
        .req    (req_d)
    );

    pm_req_reg u_out (
        .clk (clk),
        .rst (core_rst),
        .d   (req_d),
        .q   (req_q)
    );

    assign sci_out  = req_q.sci;
    assign smi_out  = req_q.smi;
    assign wake_out = req_q.wake;
endmodule

// File: rtl/pm_evt_chk.sv
`timescale 1ns/1ps
module pm_evt_chk
    import pm_evt_pkg::*;
(
    input logic             clk,
    input logic             core_rst,
    input logic             resume_rst,
    input logic             rtc_rst,
    input logic [REG_W-1:0] en_q,
    input logic             tmr_ovf_sts,
    input logic             gbl_sts,
    input logic             pbtn_sts,
    input logic             rtc_sts,
    input logic             pcie_wake_sts,
    input logic             sci_en,
    input logic             sci_out,
    input logic             smi_out,
    input logic             wake_out
);
    // R5
    tmr_smi_chk: assert property (@(posedge clk) disable iff (core_rst)
        (en_q[B_TMR] && tmr_ovf_sts && !sci_en) |=> smi_out);

    // R5
    tmr_sci_chk: assert property (@(posedge clk) disable iff (core_rst)
        (en_q[B_TMR] && tmr_ovf_sts && sci_en) |=> sci_out);

    // R6
    gbl_sci_chk: assert property (@(posedge clk) disable iff (core_rst)
        (en_q[B_GBL] && gbl_sts) |=> sci_out);

    // R7
    pbtn_wake_chk: assert property (@(posedge clk) disable iff (core_rst)
        pbtn_sts |=> wake_out);

    // R9
    pcie_block_chk: assert property (@(posedge clk) disable iff (core_rst || resume_rst || rtc_rst)
        (en_q[B_PCIE] && !pbtn_sts && !(en_q[B_RTC] && rtc_sts)) |=> !wake_out);

    // R10
    core_clr_chk: assert property (@(posedge clk) disable iff (rtc_rst)
        core_rst |=> (!en_q[B_TMR] && !en_q[B_GBL] && !en_q[B_PBTN] && !sci_out && !smi_out));
endmodule

bind pm_evt_top pm_evt_chk u_chk (
    .clk           (clk),
    .core_rst      (core_rst),
    .resume_rst    (resume_rst),
    .rtc_rst       (rtc_rst),
    .en_q          (en_q),
    .tmr_ovf_sts   (tmr_ovf_sts),
    .gbl_sts       (gbl_sts),
    .pbtn_sts      (pbtn_sts),
    .rtc_sts       (rtc_sts),
    .pcie_wake_sts (pcie_wake_sts),
    .sci_en        (sci_en),
    .sci_out       (sci_out),
    .smi_out       (smi_out),
    .wake_out      (wake_out)
);

// File: tb/pm_evt_top_tb_top.sv
`timescale 1ns/1ps
module pm_evt_top_tb_top;
    localparam logic [15:0] MASK = 16'h4521;

    logic        clk = 1'b0;
    logic        core_rst = 1'b1, resume_rst = 1'b1, rtc_rst = 1'b1, pbo_evt = 1'b0;
    logic [7:0]  io_addr = 8'h02;
    logic        io_wr = 1'b0;
    logic [1:0]  io_be = 2'b00;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic        tmr_ovf_sts = 0, gbl_sts = 0, pbtn_sts = 0, rtc_sts = 0, pcie_wake_sts = 0, sci_en = 0;
    logic        sci_out, smi_out, wake_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] mdl = '0;

    always #10 clk = ~clk;  // 50 MHz

    pm_evt_top dut_i (.*);

    function automatic logic [2:0] exp_req(logic [15:0] en, logic [4:0] s, logic se);
        // s = {pcie, rtc, pbtn, gbl, tmr}; result = {sci, smi, wake}
        logic steer, sci, smi, wake;
        steer = (en[0] & s[0]) | (en[8] & s[2]) | (en[10] & s[3]);
        sci   = (en[5] & s[1]) | (steer & se);
        smi   = steer & ~se;
        wake  = s[2] | (en[10] & s[3]) | (s[4] & ~en[14]);
        return {sci, smi, wake};
    endfunction

    function automatic logic [15:0] exp_next(logic [15:0] cur, logic cr, logic rr, logic tr, logic po,
                                             logic wr, logic [7:0] a, logic [1:0] be, logic [15:0] wd);
        logic [15:0] n;
        n = cur;
        if (wr && a == 8'h02) begin
            if (be[0]) n[7:0]  = wd[7:0];
            if (be[1]) n[15:8] = wd[15:8];
        end
        n = n & MASK;
        if (cr) begin n[0] = 1'b0; n[5] = 1'b0; n[8] = 1'b0; end
        if (rr) n[14] = 1'b0;
        if (tr || po) n[10] = 1'b0;
        return n;
    endfunction

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(string tag, logic cr, logic rr, logic tr, logic po, logic wr,
                        logic [7:0] a, logic [1:0] be, logic [15:0] wd, logic [4:0] s, logic se);
        logic [2:0]  e;
        logic [15:0] nx;
        core_rst = cr; resume_rst = rr; rtc_rst = tr; pbo_evt = po;
        io_wr = wr; io_addr = a; io_be = be; io_wdata = wd;
        {pcie_wake_sts, rtc_sts, pbtn_sts, gbl_sts, tmr_ovf_sts} = s;
        sci_en = se;
        e  = cr ? 3'b000 : exp_req(mdl, s, se);
        nx = exp_next(mdl, cr, rr, tr, po, wr, a, be, wd);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " req"}, {13'd0, sci_out, smi_out, wake_out}, {13'd0, e});
        mdl = nx;
        io_wr = 0; core_rst = 0; resume_rst = 0; rtc_rst = 0; pbo_evt = 0;
        #1;
        chk({tag, " rdata"}, io_rdata, (a == 8'h02) ? mdl : 16'h0000);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: all resets together
        step("R1 reset", 1, 1, 1, 0, 0, 8'h02, 2'b00, 16'h0, 5'b00000, 0);
        chk("R1 outputs clear", {13'd0, sci_out, smi_out, wake_out}, 16'h0);
        step("R4 reserved", 0, 0, 0, 0, 1, 8'h02, 2'b11, 16'hFFFF, 5'b00000, 0);
        chk("R4 implemented bits", io_rdata, 16'h4521);
        step("R2 other read", 0, 0, 0, 0, 0, 8'h03, 2'b00, 16'h0, 5'b00000, 0);
        step("R2 other write", 0, 0, 0, 0, 1, 8'h04, 2'b11, 16'h0000, 5'b00000, 0);
        step("R2 keep", 0, 0, 0, 0, 0, 8'h02, 2'b00, 16'h0, 5'b00000, 0);
        step("R5 tmr smi", 0, 0, 0, 0, 0, 8'h02, 2'b00, 16'h0, 5'b00001, 0);
        step("R5 tmr sci", 0, 0, 0, 0, 0, 8'h02, 2'b00, 16'h0, 5'b00001, 1);
        step("R6 gbl sci", 0, 0, 0, 0, 0, 8'h02, 2'b00, 16'h0, 5'b00010, 0);
        step("R7 pbtn sci", 0, 0, 0, 0, 0, 8'h02, 2'b00, 16'h0, 5'b00100, 1);
        step("R9 pcie blocked", 0, 0, 0, 0, 0, 8'h02, 2'b00, 16'h0, 5'b10000, 0);
        step("R3 low lane", 0, 0, 0, 0, 1, 8'h02, 2'b01, 16'h0000, 5'b00000, 0);
        step("R5 tmr disabled", 0, 0, 0, 0, 0, 8'h02, 2'b00, 16'h0, 5'b00001, 0);
        step("R3 high lane", 0, 0, 0, 0, 1, 8'h02, 2'b10, 16'h0000, 5'b00000, 0);
        step("R7 wake only", 0, 0, 0, 0, 0, 8'h02, 2'b00, 16'h0, 5'b00100, 0);
        step("R9 pcie wake", 0, 0, 0, 0, 0, 8'h02, 2'b00, 16'h0, 5'b10000, 0);
        step("R8 rtc enable", 0, 0, 0, 0, 1, 8'h02, 2'b10, 16'h0400, 5'b00000, 0);
        step("R8 rtc smi wake", 0, 0, 0, 0, 0, 8'h02, 2'b00, 16'h0, 5'b01000, 0);
        step("R8 rtc sci wake", 0, 0, 0, 0, 0, 8'h02, 2'b00, 16'h0, 5'b01000, 1);
        step("R10 core reset", 1, 0, 0, 0, 1, 8'h02, 2'b11, 16'hFFFF, 5'b11111, 1);
        chk("R10 core bits", io_rdata, 16'h4400);
        step("R12 rtc reset", 0, 0, 1, 0, 1, 8'h02, 2'b11, 16'hFFFF, 5'b00000, 0);
        chk("R12 rtc bit", io_rdata, 16'h4121);
        step("R12 override", 0, 0, 0, 1, 1, 8'h02, 2'b11, 16'hFFFF, 5'b00000, 0);
        step("R11 resume reset", 0, 1, 0, 0, 0, 8'h02, 2'b00, 16'h0, 5'b00000, 0);
        chk("R11 resume bit", io_rdata, 16'h0121);
        step("R1 reset again", 1, 1, 1, 0, 0, 8'h02, 2'b00, 16'h0, 5'b00000, 0);
        for (int i = 0; i < 3000; i++) begin
            logic cr, rr, tr, po, wr;
            logic [7:0] a;
            cr = ($urandom % 40) == 0;
            rr = ($urandom % 60) == 0;
            tr = ($urandom % 60) == 0;
            po = ($urandom % 60) == 0;
            wr = ($urandom % 4) == 0;
            a  = (($urandom % 4) == 0) ? 8'($urandom) : 8'h02;
            step("R5 R6 R7 R8 R9 R10 random", cr, rr, tr, po, wr, a, 2'($urandom),
                 16'($urandom), 5'($urandom), 1'($urandom));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule